// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block turns software interrupt requests raised by processors into per-processor pending state. A processor posts a 32-bit request word naming an interrupt number and a set of destination processors. The block records, for every destination and interrupt number, which processors asked for that interrupt. This record is a bitmap with one bit per requesting processor. It also keeps a pending flag for each destination and interrupt number.

When a destination processor takes the interrupt, it presents an acknowledge. In the same cycle the block returns the lowest-numbered requester and removes that requester from the bitmap. The interrupt stays pending until every requester has been taken.

Byte-wide writes can also add bits to a bitmap or remove bits from it directly on behalf of the writing processor. A read port shows any bitmap. Choosing between competing interrupts by priority is left to a neighbouring block.

Top module: `sgi_dispatcher`

## Requirements
- R1: After reset every pending flag and every source bitmap is zero, and the read port returns 0 for every entry.
- R2: The interrupt number comes from request-word bits 9:0. A request whose number is NUM_SGI or above changes nothing.
- R3: Filter code 0 in request bits 25:24 sends the request to the processors listed in bits 23:16, where bit 16 is processor 0. List bits at or above NUM_CPU are dropped.
- R4: Filter code 1 sends the request to every processor except the writer.
- R5: Filter code 2 sends the request to the writer only.
- R6: Filter code 3 sends the request to every processor.
- R7: For each destination, a request sets bit `writer` in that destination's bitmap for the interrupt and sets its pending flag. Bitmaps from several writers accumulate. The read port returns the bitmap of (rd_cpu_i, rd_sgi_i) in the same cycle.
- R8: An acknowledge on a pending entry raises ack_hit_o and returns the lowest set bitmap bit on ack_src_o in the same cycle. That bit is cleared at the next edge. The pending flag clears only if the bitmap is then empty; an acknowledge on a pending entry with an empty bitmap returns 0 and clears the flag.
- R9: An acknowledge on an entry that is not pending leaves ack_hit_o low and changes no state.
- R10: A clear-type byte write removes the data bits from the writer's own bitmap for the named interrupt. If that bitmap becomes empty, its pending flag clears.
- R11: A set-type byte write ORs the data bits, masked to NUM_CPU, into the writer's own bitmap and sets its pending flag, even when the data is zero.
- R12: When a clear (acknowledge or clear write) and a set (request or set write) reach the same entry in one cycle, the clear applies first and the set second.
- R13: Any request, byte write or acknowledge whose processor index is NUM_CPU or above changes nothing and produces no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid_i | input | 1 | Request word strobe |
| disp_word_i | input | 32 | Request word: number in 9:0, list in 23:16, filter in 25:24 |
| disp_cpu_i | input | 3 | Index of the processor posting the request |
| bw_valid_i | input | 1 | Byte write strobe |
| bw_set_i | input | 1 | 1 for a set-type write, 0 for a clear-type write |
| bw_sgi_i | input | SGI_W | Interrupt number the byte write targets |
| bw_cpu_i | input | 3 | Index of the writing processor |
| bw_data_i | input | 8 | Source bits to set or clear |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_sgi_i | input | SGI_W | Interrupt number being acknowledged |
| ack_cpu_i | input | 3 | Acknowledging processor |
| ack_hit_o | output | 1 | Acknowledge found the entry pending |
| ack_src_o | output | 3 | Lowest requester in the acknowledged bitmap |
| pend_o | output | NUM_CPU*NUM_SGI | Pending flags, bit cpu*NUM_SGI+sgi |
| rd_cpu_i | input | 3 | Read port processor index |
| rd_sgi_i | input | SGI_W | Read port interrupt number |
| rd_map_o | output | 8 | Bitmap of the read entry, zero-extended |

## Verification
The bench builds up one entry from three writers and acknowledges it three times. It checks that the sources come back in ascending order and that the pending flag survives the first two acknowledges. A design that cleared pending on the first acknowledge would lose the later requesters. A design that picked the highest bit would return them in reverse.

The bench lands an acknowledge and a new request on the same entry in one cycle; a design with the wrong ordering would drop the new request. It also posts requests with list bits above NUM_CPU, with oversized interrupt numbers and with absent processor indices. A design that failed to mask these would set pending flags that no real processor owns. A long mixed random phase then compares every pending flag, every acknowledge and a rotating bitmap readback against the reference model.

// File: rtl/sgi_disp_pkg.sv
package sgi_disp_pkg;

    // processor indices travel on 3-bit fields
    localparam int CPU_IDX_W = 3;
    localparam int MAX_CPU   = 8;

    typedef enum logic [1:0] {
        FILT_LIST   = 2'd0,
        FILT_OTHERS = 2'd1,
        FILT_SELF   = 2'd2,
        FILT_ALL    = 2'd3
    } filt_e;

endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode
    import sgi_disp_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  filt_e                  filt_i,
    input  logic [MAX_CPU-1:0]     list_i,
    input  logic [CPU_IDX_W-1:0]   writer_i,
    output logic [NUM_CPU-1:0]     tgt_o
);

    logic [NUM_CPU-1:0] self_oh;

    always_comb begin
        for (int c = 0; c < NUM_CPU; c++) begin
            self_oh[c] = (int'(writer_i) == c);
        end
        unique case (filt_i)
            FILT_LIST:   tgt_o = list_i[NUM_CPU-1:0];
            FILT_OTHERS: tgt_o = ~self_oh;
            FILT_SELF:   tgt_o = self_oh;
            default:     tgt_o = '1;
        endcase
    end

endmodule

// File: rtl/sgi_src_pick.sv
module sgi_src_pick
    import sgi_disp_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic [NUM_CPU-1:0]   map_i,
    output logic [CPU_IDX_W-1:0] idx_o,
    output logic [NUM_CPU-1:0]   oh_o
);

    always_comb begin
        idx_o = '0;
        oh_o  = '0;
        for (int i = NUM_CPU - 1; i >= 0; i--) begin
            if (map_i[i]) begin
                idx_o = CPU_IDX_W'(i);
                oh_o  = '0;
                oh_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sgi_dispatcher.sv
module sgi_dispatcher
    import sgi_disp_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_SGI = 16,
    localparam int SGI_W  = (NUM_SGI > 1) ? $clog2(NUM_SGI) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       disp_valid_i,
    input  logic [31:0]                disp_word_i,
    input  logic [CPU_IDX_W-1:0]       disp_cpu_i,
    input  logic                       bw_valid_i,
    input  logic                       bw_set_i,
    input  logic [SGI_W-1:0]           bw_sgi_i,
    input  logic [CPU_IDX_W-1:0]       bw_cpu_i,
    input  logic [7:0]                 bw_data_i,
    input  logic                       ack_valid_i,
    input  logic [SGI_W-1:0]           ack_sgi_i,
    input  logic [CPU_IDX_W-1:0]       ack_cpu_i,
    output logic                       ack_hit_o,
    output logic [CPU_IDX_W-1:0]       ack_src_o,
    output logic [NUM_CPU*NUM_SGI-1:0] pend_o,
    input  logic [CPU_IDX_W-1:0]       rd_cpu_i,
    input  logic [SGI_W-1:0]           rd_sgi_i,
    output logic [7:0]                 rd_map_o
);

    localparam int MAP_BITS = NUM_CPU * NUM_SGI * NUM_CPU;

    typedef struct packed {
        logic [NUM_CPU-1:0][NUM_SGI-1:0][NUM_CPU-1:0] map;
        logic [NUM_CPU-1:0][NUM_SGI-1:0]              pend;
    } state_t;

    state_t state_d, state_q;

    logic [9:0]          disp_id;
    logic                disp_ok, bw_ok, ack_ok, ack_hit;
    logic [NUM_CPU-1:0]  tgt, wr_oh, bw_bits;
    logic [NUM_CPU-1:0]  sel_map, rd_sel, pick_oh;
    logic                sel_pend;
    logic [CPU_IDX_W-1:0] pick_idx;
    logic [MAP_BITS-1:0] map_flat;

    assign disp_id = disp_word_i[9:0];
    assign disp_ok = disp_valid_i && (int'(disp_cpu_i) < NUM_CPU)
                     && (int'(disp_id) < NUM_SGI);
    assign bw_ok   = bw_valid_i && (int'(bw_cpu_i) < NUM_CPU)
                     && (int'(bw_sgi_i) < NUM_SGI);
    assign ack_ok  = ack_valid_i && (int'(ack_cpu_i) < NUM_CPU)
                     && (int'(ack_sgi_i) < NUM_SGI);
    assign bw_bits = bw_data_i[NUM_CPU-1:0];

    sgi_target_decode #(.NUM_CPU(NUM_CPU)) u_tgt (
        .filt_i   (filt_e'(disp_word_i[25:24])),
        .list_i   (disp_word_i[23:16]),
        .writer_i (disp_cpu_i),
        .tgt_o    (tgt)
    );

    sgi_src_pick #(.NUM_CPU(NUM_CPU)) u_pick (
        .map_i (sel_map),
        .idx_o (pick_idx),
        .oh_o  (pick_oh)
    );

    // entry selection for the acknowledge and read ports
    always_comb begin
        sel_map  = '0;
        sel_pend = 1'b0;
        rd_sel   = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            wr_oh[c] = (int'(disp_cpu_i) == c);
            for (int s = 0; s < NUM_SGI; s++) begin
                if (int'(ack_cpu_i) == c && int'(ack_sgi_i) == s) begin
                    sel_map  = state_q.map[c][s];
                    sel_pend = state_q.pend[c][s];
                end
                if (int'(rd_cpu_i) == c && int'(rd_sgi_i) == s) begin
                    rd_sel = state_q.map[c][s];
                end
            end
        end
    end

    assign ack_hit = ack_ok && sel_pend;

    // next-state: clears first, then sets
    always_comb begin
        logic [NUM_CPU-1:0] m;
        logic               p;
        logic               touched;
        state_d = state_q;
        for (int c = 0; c < NUM_CPU; c++) begin
            for (int s = 0; s < NUM_SGI; s++) begin
                m       = state_q.map[c][s];
                p       = state_q.pend[c][s];
                touched = 1'b0;
                if (ack_hit && int'(ack_cpu_i) == c && int'(ack_sgi_i) == s) begin
                    m       = m & ~pick_oh;
                    touched = 1'b1;
                end
                if (bw_ok && !bw_set_i && int'(bw_cpu_i) == c
                    && int'(bw_sgi_i) == s) begin
                    m       = m & ~bw_bits;
                    touched = 1'b1;
                end
                if (touched && m == '0) begin
                    p = 1'b0;
                end
                if (disp_ok && tgt[c] && int'(disp_id) == s) begin
                    m = m | wr_oh;
                    p = 1'b1;
                end
                if (bw_ok && bw_set_i && int'(bw_cpu_i) == c
                    && int'(bw_sgi_i) == s) begin
                    m = m | bw_bits;
                    p = 1'b1;
                end
                state_d.map[c][s]  = m;
                state_d.pend[c][s] = p;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ack_hit_o = ack_hit;
    assign ack_src_o = ack_hit ? pick_idx : '0;
    assign pend_o    = state_q.pend;
    assign rd_map_o  = (int'(rd_cpu_i) < NUM_CPU && int'(rd_sgi_i) < NUM_SGI)
                       ? 8'(rd_sel) : 8'd0;
    assign map_flat  = state_q.map;

endmodule

// File: rtl/sgi_dispatcher_chk.sv
module sgi_dispatcher_chk #(
    parameter int NUM_CPU = 4,
    parameter int NUM_SGI = 16,
    localparam int SGI_W  = (NUM_SGI > 1) ? $clog2(NUM_SGI) : 1
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               disp_valid_i,
    input logic [31:0]                        disp_word_i,
    input logic [2:0]                         disp_cpu_i,
    input logic                               bw_valid_i,
    input logic                               ack_valid_i,
    input logic [SGI_W-1:0]                   ack_sgi_i,
    input logic [2:0]                         ack_cpu_i,
    input logic                               ack_hit_o,
    input logic [2:0]                         ack_src_o,
    input logic [NUM_CPU*NUM_SGI-1:0]         pend_o,
    input logic [NUM_CPU*NUM_SGI*NUM_CPU-1:0] map_flat
);

    logic [NUM_CPU*NUM_SGI-1:0] busy;
    int ack_bit, self_idx;

    always_comb begin
        for (int e = 0; e < NUM_CPU * NUM_SGI; e++) begin
            busy[e] = |map_flat[e*NUM_CPU +: NUM_CPU];
        end
        ack_bit  = (int'(ack_cpu_i) * NUM_SGI + int'(ack_sgi_i)) * NUM_CPU
                   + int'(ack_src_o);
        self_idx = int'(disp_cpu_i) * NUM_SGI + int'(disp_word_i[9:0]);
    end

    // R1: pending flags are clear in the first cycle out of reset
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pend_o == '0);

    // R7: a non-empty bitmap always has its pending flag set
    p_map_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy & ~pend_o) == '0);

    // R5: self-targeted request leaves the writer pending
    p_self_disp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid_i && disp_word_i[25:24] == 2'd2
         && int'(disp_cpu_i) < NUM_CPU && int'(disp_word_i[9:0]) < NUM_SGI)
        |=> pend_o[$past(self_idx)]);

    // R8: the returned source lies in range
    p_ack_src_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit_o |-> int'(ack_src_o) < NUM_CPU);

    // R8: the returned source bit is gone after the edge when nothing sets
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit_o && !disp_valid_i && !bw_valid_i) |=> !map_flat[$past(ack_bit)]);

    // R9: no hit without an acknowledge
    p_ack_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_valid_i |-> !ack_hit_o);

endmodule

bind sgi_dispatcher sgi_dispatcher_chk #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .disp_valid_i (disp_valid_i),
    .disp_word_i  (disp_word_i),
    .disp_cpu_i   (disp_cpu_i),
    .bw_valid_i   (bw_valid_i),
    .ack_valid_i  (ack_valid_i),
    .ack_sgi_i    (ack_sgi_i),
    .ack_cpu_i    (ack_cpu_i),
    .ack_hit_o    (ack_hit_o),
    .ack_src_o    (ack_src_o),
    .pend_o       (pend_o),
    .map_flat     (map_flat)
);

// File: tb/tb_sgi_dispatcher.sv
module tb_sgi_dispatcher;

    localparam int CLK_PERIOD = 10;
    localparam int NCPU = 4;
    localparam int NSGI = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid_i = 1'b0;
    logic [31:0] disp_word_i = '0;
    logic [2:0]  disp_cpu_i = '0;
    logic        bw_valid_i = 1'b0;
    logic        bw_set_i = 1'b0;
    logic [3:0]  bw_sgi_i = '0;
    logic [2:0]  bw_cpu_i = '0;
    logic [7:0]  bw_data_i = '0;
    logic        ack_valid_i = 1'b0;
    logic [3:0]  ack_sgi_i = '0;
    logic [2:0]  ack_cpu_i = '0;
    logic        ack_hit_o;
    logic [2:0]  ack_src_o;
    logic [NCPU*NSGI-1:0] pend_o;
    logic [2:0]  rd_cpu_i = '0;
    logic [3:0]  rd_sgi_i = '0;
    logic [7:0]  rd_map_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    string cur_req = "R1";
    int rd_ptr = 0;

    int unsigned mm [NCPU][NSGI];
    bit          mp [NCPU][NSGI];

    always #(CLK_PERIOD/2) clk = ~clk;

    sgi_dispatcher #(.NUM_CPU(NCPU), .NUM_SGI(NSGI)) dut (
        .clk, .rst_n, .disp_valid_i, .disp_word_i, .disp_cpu_i,
        .bw_valid_i, .bw_set_i, .bw_sgi_i, .bw_cpu_i, .bw_data_i,
        .ack_valid_i, .ack_sgi_i, .ack_cpu_i, .ack_hit_o, .ack_src_o,
        .pend_o, .rd_cpu_i, .rd_sgi_i, .rd_map_o
    );

    task automatic chk(string req, string what, longint act, longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int lowest(int unsigned v);
        for (int i = 0; i < NCPU; i++) if (v[i]) return i;
        return -1;
    endfunction

    // compare everything visible against the model in the current cycle
    task automatic compare();
        logic [NCPU*NSGI-1:0] ep;
        int ac, asg, rc, rs, lo;
        bit ehit;
        for (int c = 0; c < NCPU; c++)
            for (int s = 0; s < NSGI; s++) ep[c*NSGI+s] = mp[c][s];
        chk(cur_req, "pending", longint'(pend_o), longint'(ep));
        ac = int'(ack_cpu_i); asg = int'(ack_sgi_i);
        ehit = ack_valid_i && ac < NCPU && asg < NSGI && mp[ac][asg];
        chk(cur_req, "ack_hit", longint'(ack_hit_o), longint'(ehit));
        if (ehit) begin
            lo = lowest(mm[ac][asg]);
            chk(cur_req, "ack_src", longint'(ack_src_o), longint'(lo < 0 ? 0 : lo));
        end
        rc = int'(rd_cpu_i); rs = int'(rd_sgi_i);
        chk(cur_req, "readback", longint'(rd_map_o),
            longint'((rc < NCPU && rs < NSGI) ? mm[rc][rs] : 0));
    endtask

    task automatic model_edge();
        int unsigned nm [NCPU][NSGI];
        bit np [NCPU][NSGI];
        bit tch [NCPU][NSGI];
        int ac, asg, bc, bs, wc, id, lo;
        int unsigned msk, tg;
        msk = (1 << NCPU) - 1;
        nm = mm; np = mp;
        for (int c = 0; c < NCPU; c++) for (int s = 0; s < NSGI; s++) tch[c][s] = 0;
        ac = int'(ack_cpu_i); asg = int'(ack_sgi_i);
        bc = int'(bw_cpu_i);  bs = int'(bw_sgi_i);
        if (ack_valid_i && ac < NCPU && asg < NSGI && mp[ac][asg]) begin
            lo = lowest(nm[ac][asg]);
            if (lo >= 0) nm[ac][asg] &= ~(32'd1 << lo);
            tch[ac][asg] = 1;
        end
        if (bw_valid_i && !bw_set_i && bc < NCPU && bs < NSGI) begin
            nm[bc][bs] &= ~(int'(bw_data_i) & msk);
            tch[bc][bs] = 1;
        end
        for (int c = 0; c < NCPU; c++)
            for (int s = 0; s < NSGI; s++)
                if (tch[c][s] && nm[c][s] == 0) np[c][s] = 0;
        wc = int'(disp_cpu_i); id = int'(disp_word_i[9:0]);
        if (disp_valid_i && wc < NCPU && id < NSGI) begin
            case (disp_word_i[25:24])
                2'd0: tg = int'(disp_word_i[23:16]) & msk;
                2'd1: tg = msk & ~(32'd1 << wc);
                2'd2: tg = 32'd1 << wc;
                default: tg = msk;
            endcase
            for (int t = 0; t < NCPU; t++)
                if (tg[t]) begin nm[t][id] |= (32'd1 << wc); np[t][id] = 1; end
        end
        if (bw_valid_i && bw_set_i && bc < NCPU && bs < NSGI) begin
            nm[bc][bs] |= int'(bw_data_i) & msk;
            np[bc][bs] = 1;
        end
        mm = nm; mp = np;
    endtask

    // one cycle: inputs already driven after a falling edge
    task automatic cycle();
        #1;
        compare();
        @(posedge clk);
        if (rst_n) model_edge();
        @(negedge clk);
        disp_valid_i = 0; bw_valid_i = 0; ack_valid_i = 0;
        rd_ptr = (rd_ptr + 1) % (NCPU * NSGI);
        rd_cpu_i = 3'(rd_ptr / NSGI);
        rd_sgi_i = 4'(rd_ptr % NSGI);
    endtask

    task automatic disp(int cpu, int filt, int list, int id);
        disp_valid_i = 1;
        disp_cpu_i = 3'(cpu);
        disp_word_i = {6'd0, 2'(filt), 8'(list), 6'd0, 10'(id)};
    endtask

    task automatic ack(int cpu, int id);
        ack_valid_i = 1; ack_cpu_i = 3'(cpu); ack_sgi_i = 4'(id);
    endtask

    task automatic bwr(bit set, int cpu, int id, int data);
        bw_valid_i = 1; bw_set_i = set; bw_cpu_i = 3'(cpu);
        bw_sgi_i = 4'(id); bw_data_i = 8'(data);
    endtask

    task automatic peek(int cpu, int id);
        rd_cpu_i = 3'(cpu); rd_sgi_i = 4'(id);
    endtask

    initial begin
        for (int c = 0; c < NCPU; c++)
            for (int s = 0; s < NSGI; s++) begin mm[c][s] = 0; mp[c][s] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: sweep the read port over every entry
        cur_req = "R1";
        for (int c = 0; c < NCPU; c++)
            for (int s = 0; s < NSGI; s++) begin
                peek(c, s); #1;
                chk("R1", "reset readback", longint'(rd_map_o), 0);
                @(negedge clk);
            end
        cycle();

        cur_req = "R5"; disp(1, 2, 0, 3); cycle(); peek(1, 3); cycle();
        chk("R5", "self target pend", longint'(pend_o[1*NSGI+3]), 1);

        cur_req = "R3"; disp(0, 0, 8'hF3, 5); cycle(); peek(1, 5); cycle();
        cur_req = "R4"; disp(2, 1, 0, 7); cycle(); peek(2, 7); cycle();
        chk("R4", "writer not pending", longint'(pend_o[2*NSGI+7]), 0);
        cur_req = "R6"; disp(3, 3, 0, 9); cycle(); peek(3, 9); cycle();

        cur_req = "R2"; disp(0, 3, 0, 16); cycle();
        disp(1, 3, 0, 10'h203); cycle();
        chk("R2", "oversized id ignored", longint'(pend_o[0*NSGI+0]), 0);

        cur_req = "R13"; disp(5, 3, 0, 11); cycle();
        bwr(1, 6, 11, 8'h0F); cycle(); ack(4, 3); cycle();
        chk("R13", "absent cpu ignored", longint'(pend_o[2*NSGI+11]), 0);

        // R7: three writers accumulate on cpu2 / sgi 2
        cur_req = "R7";
        disp(3, 0, 8'h04, 2); cycle();
        disp(0, 0, 8'h04, 2); cycle();
        disp(1, 0, 8'h04, 2); peek(2, 2); cycle();
        peek(2, 2); #1;
        chk("R7", "accumulated map", longint'(rd_map_o), 8'h0B);
        @(negedge clk);

        // R8: ascending sources, pending held until the last
        cur_req = "R8";
        ack(2, 2); #1; chk("R8", "first src", longint'(ack_src_o), 0); cycle();
        ack(2, 2); #1; chk("R8", "second src", longint'(ack_src_o), 1); cycle();
        chk("R8", "still pending", longint'(pend_o[2*NSGI+2]), 1);
        ack(2, 2); #1; chk("R8", "third src", longint'(ack_src_o), 3); cycle();
        chk("R8", "pending dropped", longint'(pend_o[2*NSGI+2]), 0);

        cur_req = "R9"; ack(2, 2); cycle(); ack(0, 14); cycle();

        cur_req = "R10"; bwr(1, 1, 6, 8'h05); cycle();
        bwr(0, 1, 6, 8'h04); peek(1, 6); cycle();
        bwr(0, 1, 6, 8'h01); cycle(); peek(1, 6); cycle();
        chk("R10", "cleared pend", longint'(pend_o[1*NSGI+6]), 0);

        cur_req = "R11"; bwr(1, 3, 12, 8'h00); cycle();
        chk("R11", "zero set pend", longint'(pend_o[3*NSGI+12]), 1);
        bwr(1, 3, 12, 8'hF2); peek(3, 12); cycle(); peek(3, 12); cycle();
        ack(3, 12); cycle(); ack(3, 12); cycle();

        // R12: clear and set on the same entry in one cycle
        cur_req = "R12";
        disp(2, 0, 8'h01, 4); cycle();
        ack(0, 4); disp(2, 0, 8'h01, 4); cycle();
        chk("R12", "set after ack", longint'(pend_o[0*NSGI+4]), 1);
        bwr(0, 0, 4, 8'h04); disp(2, 0, 8'h01, 4); peek(0, 4); cycle();
        peek(0, 4); cycle();

        // mixed random traffic
        cur_req = "R7";
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 2) == 0)
                disp($urandom_range(0, 4), $urandom_range(0, 3),
                     $urandom_range(0, 255), $urandom_range(0, 17));
            if ($urandom_range(0, 3) == 0)
                bwr(1'($urandom_range(0, 1)), $urandom_range(0, 4),
                    $urandom_range(0, 15), $urandom_range(0, 255));
            if ($urandom_range(0, 1) == 0)
                ack($urandom_range(0, 4), $urandom_range(0, 15));
            cycle();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule